// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block is the control unit and datapath for the memory-operand instructions of a small 16-bit computer with one accumulator. A step counter walks through fetch, decode and an optional indirection step. It then runs the execute steps of the decoded instruction and clears itself, so that the next instruction starts again at step 0. Words are 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the operand address. The 4096-word memory sits inside the block.

Software loads programs and data through a write port while `run` is low, and reads words back through a separate read port. While `run` is high the sequencer advances one step per clock. While `run` is low, every architectural register and the step counter hold their values.

Top module: `mri_seq`

## Requirements
- R1: After reset, `pc`, `acc`, `e_flag` and `step` are all zero.
- R2: Fetch uses step 0 to copy PC into the address register and step 1 to read the instruction and increment PC by one (12-bit wrap).
- R3: Opcodes decode one-hot: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 non-memory group. Decode happens at step 2.
- R4: When bit 15 of the instruction is 1 and the opcode is 0 to 6, the effective address is bits 11:0 of the memory word at the operand address, read at step 3. Otherwise the effective address is the operand address and step 3 is an idle step.
- R5: AND sets ACC to ACC bitwise-AND M[EA], leaves E unchanged and takes 6 steps.
- R6: ADD sets {E, ACC} to the 17-bit sum ACC + M[EA] and takes 6 steps.
- R7: LDA sets ACC to M[EA], leaves E unchanged and takes 6 steps.
- R8: STA writes ACC to M[EA] and ends after step 4, taking 5 steps.
- R9: BUN loads PC with EA and takes 5 steps. Indirect BUN through a saved word returns from a subroutine.
- R10: BSA writes the return address (the incremented PC, zero-extended) to M[EA], sets PC to EA+1 and takes 6 steps.
- R11: ISZ writes M[EA]+1 back to M[EA], increments PC once more when that result is zero, and takes 7 steps (step 0 to step 6). `step` never exceeds 6.
- R12: Opcode 7 ends at step 2, taking 3 steps, and changes nothing but the PC increment done at fetch.
- R13: While `run` is low, `pc`, `acc`, `e_flag` and `step` hold their values, even in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Advance the sequencer one step per clock when high |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | 12 | Memory load address |
| ld_data | input | 16 | Memory load data |
| rd_addr | input | 12 | Memory inspection address |
| rd_data | output | 16 | Memory word at `rd_addr`, combinational |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| e_flag | output | 1 | Carry flag |
| step | output | 3 | Current timing step |
| instr_done | output | 1 | High during the last step of an instruction while running |

## Verification
The checker watches several properties on every cycle: that the decoder output is one-hot, that `step` never exceeds 6, that PC increments after step 1, and that state freezes while `run` is low. It also confirms that STA, BUN and the non-memory group end at their fixed steps, that BSA continues to step 5, and that `instr_done` returns the counter to zero. The data results are left to the bench scenarios: AND, ADD carry, LDA, the word written by STA, the BSA/indirect-BUN round trip, the ISZ skip on wrap to zero, and indirect resolution. The bench compares each of these against an instruction-level model.

// File: rtl/mri_pkg.sv
package mri_pkg;
  localparam int DW    = 16;
  localparam int AW    = 12;
  localparam int OPW   = 3;
  localparam int NOP   = 1 << OPW;
  localparam int SCW   = 3;
  localparam int NSTEP = 7;

  localparam logic [OPW-1:0] OP_AND = 3'd0;
  localparam logic [OPW-1:0] OP_ADD = 3'd1;
  localparam logic [OPW-1:0] OP_LDA = 3'd2;
  localparam logic [OPW-1:0] OP_STA = 3'd3;
  localparam logic [OPW-1:0] OP_BUN = 3'd4;
  localparam logic [OPW-1:0] OP_BSA = 3'd5;
  localparam logic [OPW-1:0] OP_ISZ = 3'd6;
  localparam logic [OPW-1:0] OP_NMR = 3'd7;

  function automatic logic [DW:0] add_carry(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DW-1:0] inc_word(input logic [DW-1:0] a);
    return a + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [AW-1:0] inc_addr(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/mri_decoder.sv
module mri_decoder #(
  parameter int SW = 3,
  localparam int NO = 1 << SW
) (
  input  logic [SW-1:0] sel,
  output logic [NO-1:0] y
);
  for (genvar g = 0; g < NO; g++) begin : g_line
    assign y[g] = (sel == SW'(g));
  end
endmodule

// File: rtl/mri_timer.sv
module mri_timer #(
  parameter int SCW   = 3,
  parameter int NSTEP = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  output logic [SCW-1:0]   sc,
  output logic [NSTEP-1:0] t
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sc <= '0;
    else if (run) sc <= clr ? '0 : sc + 1'b1;
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_t
    assign t[g] = (sc == SCW'(g));
  end
endmodule

// File: rtl/mri_mem.sv
module mri_mem #(
  parameter int DW = 16,
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] qa,
  input  logic [AW-1:0] rb,
  output logic [DW-1:0] qb
);
  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign qa = arr[ra];
  assign qb = arr[rb];
endmodule

// File: rtl/mri_seq.sv
module mri_seq
  import mri_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          e_flag,
  output logic [SCW-1:0] step,
  output logic          instr_done
);
  logic [AW-1:0]    ar_q, pc_q;
  logic [DW-1:0]    dr_q, ac_q, ir_q, mem_q;
  logic             e_q, ind_q;
  logic [NOP-1:0]   dec;
  logic [NSTEP-1:0] t;
  logic [SCW-1:0]   sc;
  logic             clr, ex_we, mem_we;
  logic [AW-1:0]    mem_wa;
  logic [DW-1:0]    ex_wd, mem_wd;
  logic [DW:0]      sum;

  mri_decoder #(.SW(OPW)) u_dec (.sel(ir_q[DW-2 -: OPW]), .y(dec));

  mri_timer #(.SCW(SCW), .NSTEP(NSTEP)) u_tim (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .sc(sc), .t(t)
  );

  // end-of-instruction conditions, one per finishing step
  assign clr = (t[2] && dec[OP_NMR])
             || (t[4] && (dec[OP_STA] || dec[OP_BUN]))
             || (t[5] && (dec[OP_AND] || dec[OP_ADD] || dec[OP_LDA] || dec[OP_BSA]))
             || t[6];

  assign ex_we = run && ((t[4] && (dec[OP_STA] || dec[OP_BSA])) || (t[6] && dec[OP_ISZ]));
  assign ex_wd = dec[OP_STA] ? ac_q : (dec[OP_BSA] ? {{(DW-AW){1'b0}}, pc_q} : dr_q);

  assign mem_we = ld_en || ex_we;
  assign mem_wa = ld_en ? ld_addr : ar_q;
  assign mem_wd = ld_en ? ld_data : ex_wd;

  mri_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .ra(ar_q), .qa(mem_q), .rb(rd_addr), .qb(rd_data)
  );

  assign sum = add_carry(ac_q, dr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0; pc_q <= '0; dr_q <= '0; ac_q <= '0;
      ir_q <= '0; e_q <= 1'b0; ind_q <= 1'b0;
    end else if (run) begin
      if (t[0]) ar_q <= pc_q;
      if (t[1]) begin
        ir_q <= mem_q;
        pc_q <= inc_addr(pc_q);
      end
      if (t[2]) begin
        ar_q  <= ir_q[AW-1:0];
        ind_q <= ir_q[DW-1];
      end
      if (t[3] && ind_q) ar_q <= mem_q[AW-1:0];
      if (t[4]) begin
        if (dec[OP_AND] || dec[OP_ADD] || dec[OP_LDA] || dec[OP_ISZ]) dr_q <= mem_q;
        if (dec[OP_BUN]) pc_q <= ar_q;
        if (dec[OP_BSA]) ar_q <= inc_addr(ar_q);
      end
      if (t[5]) begin
        if (dec[OP_AND]) ac_q <= ac_q & dr_q;
        if (dec[OP_ADD]) {e_q, ac_q} <= sum;
        if (dec[OP_LDA]) ac_q <= dr_q;
        if (dec[OP_BSA]) pc_q <= ar_q;
        if (dec[OP_ISZ]) dr_q <= inc_word(dr_q);
      end
      if (t[6] && dec[OP_ISZ] && (dr_q == '0)) pc_q <= inc_addr(pc_q);
    end
  end

  assign pc         = pc_q;
  assign acc        = ac_q;
  assign e_flag     = e_q;
  assign step       = sc;
  assign instr_done = run && clr;
endmodule

// File: rtl/mri_seq_chk.sv
module mri_seq_chk
  import mri_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic [SCW-1:0] sc,
  input logic [NOP-1:0] dec,
  input logic [AW-1:0]  pc_q,
  input logic [DW-1:0]  ac_q,
  input logic           e_q,
  input logic           instr_done
);
  p_dec_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec) == 1);

  p_step_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= 3'd6);

  p_fetch_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == 3'd1) |=> pc_q == $past(pc_q) + 12'd1);

  p_sta_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == 3'd4 && dec[OP_STA]) |=> sc == 3'd0);

  p_bun_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == 3'd4 && dec[OP_BUN]) |=> sc == 3'd0);

  p_bsa_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == 3'd4 && dec[OP_BSA]) |=> sc == 3'd5);

  p_nonmem_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == 3'd2 && dec[OP_NMR]) |=> sc == 3'd0);

  p_done_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> sc == 3'd0);

  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc_q) && $stable(ac_q) && $stable(e_q) && $stable(sc)));
endmodule

bind mri_seq mri_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sc(sc), .dec(dec),
  .pc_q(pc_q), .ac_q(ac_q), .e_q(e_q), .instr_done(instr_done)
);

// File: tb/mri_seq_test.sv
module mri_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [11:0] pc;
  logic [15:0] acc;
  logic        e_flag;
  logic [2:0]  step;
  logic        instr_done;

  int n_chk = 0;
  int n_fail = 0;

  logic [15:0] mm [4096];
  logic [11:0] mpc;
  logic [15:0] mac;
  logic        me;

  always #(CLK_PERIOD/2) clk = ~clk;

  mri_seq uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_addr(rd_addr), .rd_data(rd_data), .pc(pc),
    .acc(acc), .e_flag(e_flag), .step(step), .instr_done(instr_done)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [15:0] iw);
    string s;
    case (iw[14:12])
      3'd0: s = "R5";
      3'd1: s = "R6";
      3'd2: s = "R7";
      3'd3: s = "R8";
      3'd4: s = "R9";
      3'd5: s = "R10";
      3'd6: s = "R11";
      default: s = "R12";
    endcase
    if (iw[15] && iw[14:12] != 3'd7) s = {s, "/R4"};
    return s;
  endfunction

  function automatic int op_steps(input logic [2:0] op);
    case (op)
      3'd3, 3'd4: return 5;
      3'd6:       return 7;
      3'd7:       return 3;
      default:    return 6;
    endcase
  endfunction

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mm[a] = d;
  endtask

  // instruction-level reference model
  task automatic model(output int steps, output logic [11:0] ea);
    logic [15:0] iw, v;
    logic [16:0] s;
    iw = mm[mpc];
    mpc = mpc + 12'd1;
    ea = iw[11:0];
    if (iw[15] && iw[14:12] != 3'd7) ea = mm[ea][11:0];
    steps = op_steps(iw[14:12]);
    case (iw[14:12])
      3'd0: mac = mac & mm[ea];
      3'd1: begin s = {1'b0, mac} + {1'b0, mm[ea]}; me = s[16]; mac = s[15:0]; end
      3'd2: mac = mm[ea];
      3'd3: mm[ea] = mac;
      3'd4: mpc = ea;
      3'd5: begin mm[ea] = {4'h0, mpc}; mpc = ea + 12'd1; end
      3'd6: begin v = mm[ea] + 16'd1; mm[ea] = v; if (v == 16'd0) mpc = mpc + 12'd1; end
      default: ;
    endcase
  endtask

  task automatic exec_rtl(output int cnt);
    @(negedge clk);
    run = 1'b1;
    cnt = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end while (step != 3'd0 && cnt < 20);
    run = 1'b0;
  endtask

  task automatic step_check(input int pre);
    int es, c;
    logic [11:0] ea;
    string tag;
    tag = op_tag(mm[mpc]);
    model(es, ea);
    exec_rtl(c);
    chk(tag, "step count (R3)", 32'(c + pre), 32'(es));
    chk(tag, "pc (R2)", {20'd0, pc}, {20'd0, mpc});
    chk(tag, "acc", {16'd0, acc}, {16'd0, mac});
    chk(tag, "e_flag", {31'd0, e_flag}, {31'd0, me});
    rd_addr = ea;
    #1;
    chk(tag, "mem[ea]", {16'd0, rd_data}, {16'd0, mm[ea]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [11:0] p0;
    logic [2:0]  s0;
    void'($urandom(32'd1357));
    mpc = '0; mac = '0; me = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "pc", {20'd0, pc}, 32'd0);
    chk("R1", "acc", {16'd0, acc}, 32'd0);
    chk("R1", "e_flag", {31'd0, e_flag}, 32'd0);
    chk("R1", "step", {29'd0, step}, 32'd0);
    for (int a = 0; a < 4096; a++) put(12'(a), 16'h0000);

    // R7 then R6: load and add with carry out
    put(12'h200, 16'h8000); put(12'h000, 16'h2200); step_check(0);
    put(12'h201, 16'h8001); put(12'h001, 16'h1201); step_check(0);
    // R10 call, R9/R4 return through saved word
    put(12'h002, 16'h5300); step_check(0);
    put(12'h301, 16'hC300); step_check(0);
    // R11: wrap to zero skips
    put(12'h400, 16'hFFFF); put(12'h003, 16'h6400); step_check(0);
    // R12: non-memory group
    put(12'h005, 16'hF123); step_check(0);
    // R8: store accumulator
    put(12'h006, 16'h3500); step_check(0);
    // R5: and with mask
    put(12'h202, 16'h00FF); put(12'h007, 16'h0202); step_check(0);
    // R13: stall in mid-instruction
    put(12'h210, 16'hA5A5); put(12'h008, 16'h2210);
    @(negedge clk); run = 1'b1;
    @(posedge clk); @(negedge clk); run = 1'b0;
    s0 = step; p0 = pc;
    repeat (4) @(negedge clk);
    chk("R13", "step held", {29'd0, step}, {29'd0, s0});
    chk("R13", "pc held", {20'd0, pc}, {20'd0, p0});
    step_check(1);

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic [2:0]  op;
      logic        ind;
      logic [11:0] a, tgt;
      logic [15:0] d;
      op  = 3'($urandom % 8);
      ind = 1'($urandom % 2);
      a   = 12'($urandom);
      tgt = 12'($urandom);
      case ($urandom % 4)
        0: d = 16'hFFFF;
        1: d = 16'h0000;
        default: d = 16'($urandom);
      endcase
      if (ind) begin
        put(tgt, d);
        put(a, {4'($urandom), tgt});
      end else begin
        put(a, d);
      end
      put(mpc, {ind, op, a});
      step_check(0);
    end

    summary();
    $finish;
  end
endmodule